// File: doc/BRIEF.md
# CAM Match Status Register

This block produces the 32-bit status word of a small content-addressable memory. It takes the per-entry match vector from the array's parallel comparators and the per-entry two-bit validity tags. A compare strobe is either automatic, in which case only valid entries count, or forced, in which case it comes with a validity condition and only entries carrying exactly that tag count. From the entries that qualify, the block finds the matching entry with the highest priority. It also detects more than one hit and latches three active-low flags together with the match address.

The block also records the skip and empty tag of the last entry read or moved, passed in with an access strobe. It reports whether any entry is still free. The host reads the resulting word as the default command-read value. Each entry's tag is {skip, empty}. The tag 00 means valid, and reset leaves every entry at 01, which means empty. The array storage and the host bus sit outside the block.

Top module: `camStatusTop`

## Requirements
- R1: While reset is active and before any strobe has arrived, the status word reads 32'hFFFF_FFFF. The last-access field (bits 29:28) reads 11 until the first access strobe.
- R2: Bit 31 goes low one clock after a cycle in which no entry has its empty bit set. It is high one clock after any cycle in which at least one entry is empty.
- R3: One clock after an access strobe, bits 29:28 hold {skip, empty} of the accessed entry, with skip in bit 29. With no access strobe, bits 29:28 keep their value.
- R4: One clock after a compare strobe, bit 0 is low if at least one entry qualified and matched, and high otherwise.
- R5: One clock after a compare strobe, bit 30 is low if two or more entries qualified and matched, and high otherwise.
- R6: One clock after a compare strobe, bits 27:1 hold the lowest index among qualified matching entries, zero-extended. If none qualified and matched, the field is all ones.
- R7: For an automatic compare (forced input low), an entry qualifies only when its tag is skip=0, empty=0.
- R8: For a forced compare, an entry qualifies only when its {skip, empty} tag equals the {skip, empty} condition given with the strobe.
- R9: Bits 30, 27:1 and 0 keep their value in every cycle without a compare strobe, whatever the match vector and tags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| entryMatch | input | NUM_ENTRIES | Raw per-entry comparator hit |
| entrySkip | input | NUM_ENTRIES | Per-entry skip tag bit |
| entryEmpty | input | NUM_ENTRIES | Per-entry empty tag bit |
| cmpStrobe | input | 1 | Latch compare results this cycle |
| cmpForced | input | 1 | 1: forced compare using the given condition; 0: automatic |
| cmpSkip | input | 1 | Skip bit of the forced validity condition |
| cmpEmpty | input | 1 | Empty bit of the forced validity condition |
| accStrobe | input | 1 | An entry was read or moved this cycle |
| accSkip | input | 1 | Skip tag of the accessed entry |
| accEmpty | input | 1 | Empty tag of the accessed entry |
| statusWord | output | 32 | Packed status word |

## Verification
The checker watches several relations on every cycle. It follows the full flag against the previous cycle's empty bits and the latching of the access tag. It confirms that the compare fields hold without a compare strobe. It also checks consistency between the fields: a multiple hit implies a hit, no hit implies an all-ones address, and any reported address is a real entry index. Whether the reported address is really the lowest qualifying index, and whether the automatic and forced qualification rules pick the right entries, can only be shown by the bench's scenarios. These compare every word against a reference scan of the match vector and tags.

// File: rtl/camStatusPkg.sv
package camStatusPkg;

  localparam int STATUS_W     = 32;
  localparam int ADDR_FIELD_W = 27;

  // validity tag {skip, empty}
  localparam logic [1:0] TAG_VALID = 2'b00;

  typedef struct packed {
    logic       loadCmp;
    logic [1:0] cond;
    logic       loadAcc;
    logic [1:0] accTag;
  } ctrlStrobes_t;

endpackage

// File: rtl/camStatusCtrl.sv
module camStatusCtrl
  import camStatusPkg::*;
(
  input  logic         cmpStrobe,
  input  logic         cmpForced,
  input  logic         cmpSkip,
  input  logic         cmpEmpty,
  input  logic         accStrobe,
  input  logic         accSkip,
  input  logic         accEmpty,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes.loadCmp = cmpStrobe;
    strobes.cond    = cmpForced ? {cmpSkip, cmpEmpty} : TAG_VALID;
    strobes.loadAcc = accStrobe;
    strobes.accTag  = {accSkip, accEmpty};
  end

endmodule

// File: rtl/camStatusDp.sv
module camStatusDp
  import camStatusPkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_ENTRIES-1:0] entryMatch,
  input  logic [NUM_ENTRIES-1:0] entrySkip,
  input  logic [NUM_ENTRIES-1:0] entryEmpty,
  input  ctrlStrobes_t           strobes,
  output logic [STATUS_W-1:0]    statusWord
);

  localparam int ADDR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [NUM_ENTRIES-1:0] ONE_N = NUM_ENTRIES'(1);

  logic [NUM_ENTRIES-1:0]  qual;
  logic [ADDR_W-1:0]       priAddr;
  logic                    anyHit;
  logic                    multiHit;

  logic                    fullN;
  logic                    multiN;
  logic [1:0]              accTag;
  logic [ADDR_FIELD_W-1:0] addrField;
  logic                    matchN;

  // per-entry qualification against the requested validity condition
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_qual
    assign qual[i] = entryMatch[i] & ({entrySkip[i], entryEmpty[i]} == strobes.cond);
  end

  // lowest index wins
  always_comb begin
    priAddr = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (qual[i]) priAddr = ADDR_W'(i);
    end
  end

  assign anyHit   = |qual;
  assign multiHit = |(qual & (qual - ONE_N));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullN     <= 1'b1;
      multiN    <= 1'b1;
      accTag    <= 2'b11;
      addrField <= '1;
      matchN    <= 1'b1;
    end else begin
      fullN <= |entryEmpty;
      if (strobes.loadAcc) accTag <= strobes.accTag;
      if (strobes.loadCmp) begin
        matchN    <= ~anyHit;
        multiN    <= ~multiHit;
        addrField <= anyHit ? ADDR_FIELD_W'(priAddr) : '1;
      end
    end
  end

  assign statusWord = {fullN, multiN, accTag, addrField, matchN};

endmodule

// File: rtl/camStatusTop.sv
module camStatusTop
  import camStatusPkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_ENTRIES-1:0] entryMatch,
  input  logic [NUM_ENTRIES-1:0] entrySkip,
  input  logic [NUM_ENTRIES-1:0] entryEmpty,
  input  logic                   cmpStrobe,
  input  logic                   cmpForced,
  input  logic                   cmpSkip,
  input  logic                   cmpEmpty,
  input  logic                   accStrobe,
  input  logic                   accSkip,
  input  logic                   accEmpty,
  output logic [31:0]            statusWord
);

  ctrlStrobes_t strobes;

  camStatusCtrl u_ctrl (
    .cmpStrobe (cmpStrobe),
    .cmpForced (cmpForced),
    .cmpSkip   (cmpSkip),
    .cmpEmpty  (cmpEmpty),
    .accStrobe (accStrobe),
    .accSkip   (accSkip),
    .accEmpty  (accEmpty),
    .strobes   (strobes)
  );

  camStatusDp #(.NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .entryMatch (entryMatch),
    .entrySkip  (entrySkip),
    .entryEmpty (entryEmpty),
    .strobes    (strobes),
    .statusWord (statusWord)
  );

endmodule

// File: rtl/camStatusChk.sv
module camStatusChk #(
  parameter int NUM_ENTRIES = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_ENTRIES-1:0] entryEmpty,
  input logic                   cmpStrobe,
  input logic                   accStrobe,
  input logic                   accSkip,
  input logic                   accEmpty,
  input logic [31:0]            statusWord
);

  a_r2_full_high: assert property (@(posedge clk) disable iff (!rstN)
    (|entryEmpty) |=> statusWord[31]);

  a_r2_full_low: assert property (@(posedge clk) disable iff (!rstN)
    !(|entryEmpty) |=> !statusWord[31]);

  a_r3_acc_tag: assert property (@(posedge clk) disable iff (!rstN)
    accStrobe |=> statusWord[29:28] == $past({accSkip, accEmpty}));

  a_r3_acc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !accStrobe |=> $stable(statusWord[29:28]));

  a_r5_multi_implies_hit: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[30] |-> !statusWord[0]);

  a_r6_nohit_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[0] |-> (&statusWord[27:1]));

  a_r6_addr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[0] |-> (statusWord[27:1] < 27'(NUM_ENTRIES)));

  a_r9_cmp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmpStrobe |=> $stable({statusWord[30], statusWord[27:0]}));

endmodule

bind camStatusTop camStatusChk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .entryEmpty (entryEmpty),
  .cmpStrobe  (cmpStrobe),
  .accStrobe  (accStrobe),
  .accSkip    (accSkip),
  .accEmpty   (accEmpty),
  .statusWord (statusWord)
);

// File: tb/tb_camStatusTop.sv
module tb_camStatusTop;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] entryMatch = '0;
  logic [N-1:0] entrySkip = '0;
  logic [N-1:0] entryEmpty = '1;
  logic         cmpStrobe = 1'b0;
  logic         cmpForced = 1'b0;
  logic         cmpSkip = 1'b0;
  logic         cmpEmpty = 1'b0;
  logic         accStrobe = 1'b0;
  logic         accSkip = 1'b0;
  logic         accEmpty = 1'b0;
  logic [31:0]  statusWord;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  // reference model state
  logic        refMultiN = 1'b1;
  logic [1:0]  refAcc = 2'b11;
  logic [26:0] refAddr = '1;
  logic        refMatchN = 1'b1;

  camStatusTop #(.NUM_ENTRIES(N)) dut (
    .clk(clk), .rstN(rstN), .entryMatch(entryMatch), .entrySkip(entrySkip),
    .entryEmpty(entryEmpty), .cmpStrobe(cmpStrobe), .cmpForced(cmpForced),
    .cmpSkip(cmpSkip), .cmpEmpty(cmpEmpty), .accStrobe(accStrobe),
    .accSkip(accSkip), .accEmpty(accEmpty), .statusWord(statusWord)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic checkWord(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pop items whose result is due in this cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      checkWord(statusWord, it.exp, it.tag);
    end
  end

  // driver: one cycle of stimulus, model update, expected item push
  task automatic step(input logic [N-1:0] m, input logic [N-1:0] s, input logic [N-1:0] e,
                      input logic cs, input logic cf, input logic [1:0] cond,
                      input logic as, input logic [1:0] at, input string tag);
    logic [1:0] want;
    int first;
    int cnt;
    @(negedge clk);
    entryMatch = m; entrySkip = s; entryEmpty = e;
    cmpStrobe = cs; cmpForced = cf; {cmpSkip, cmpEmpty} = cond;
    accStrobe = as; {accSkip, accEmpty} = at;
    if (cs) begin
      want  = cf ? cond : 2'b00;
      first = -1;
      cnt   = 0;
      for (int i = 0; i < N; i++) begin
        if (m[i] && ({s[i], e[i]} == want)) begin
          if (first < 0) first = i;
          cnt++;
        end
      end
      refMatchN = (cnt == 0);
      refMultiN = (cnt < 2);
      refAddr   = (cnt == 0) ? '1 : 27'(first);
    end
    if (as) refAcc = at;
    sbq.push_back('{due: cyc + 1, exp: {(|e), refMultiN, refAcc, refAddr, refMatchN}, tag: tag});
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog: got timeout expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkWord(statusWord, 32'hFFFF_FFFF, "R1 reset word");

    step('0, '0, '1, 0, 0, 2'b00, 0, 2'b00, "R2 R9 idle all empty");
    step(16'h0088, '0, 16'hF000, 1, 0, 2'b00, 0, 2'b00, "R4 R5 R6 two hits lowest 3");
    step(16'h0001, '0, 16'hF000, 0, 0, 2'b00, 0, 2'b00, "R9 hold without strobe");
    step(16'h0400, '0, 16'hF000, 1, 0, 2'b00, 0, 2'b00, "R5 R6 single hit 10");
    step(16'hF000, '0, 16'hF000, 1, 0, 2'b00, 0, 2'b00, "R7 auto ignores empty entries");
    step(16'h00A0, 16'h00F0, 16'hF000, 1, 1, 2'b10, 0, 2'b00, "R8 forced skip tag");
    step(16'h8000, 16'h00F0, 16'hF000, 1, 1, 2'b01, 0, 2'b00, "R8 R6 forced empty top entry");
    step(16'h000F, 16'h00F0, 16'hF000, 1, 1, 2'b10, 0, 2'b00, "R8 R6 forced no qualifier");
    step(16'hFFFF, '0, '0, 0, 0, 2'b00, 0, 2'b00, "R2 full low");
    step(16'h0001, '0, '0, 1, 0, 2'b00, 0, 2'b00, "R6 entry 0");
    step('0, '0, '0, 0, 0, 2'b00, 1, 2'b01, "R3 access tag 01");
    step(16'hFFFF, '0, '0, 1, 0, 2'b00, 1, 2'b10, "R3 R4 R5 access and compare");
    step('0, '0, '1, 0, 0, 2'b00, 0, 2'b00, "R2 R3 R9 full high hold");
    step('0, '0, '1, 0, 0, 2'b00, 1, 2'b00, "R3 access tag 00");
    step(16'hFFFF, '0, '1, 1, 0, 2'b00, 0, 2'b00, "R7 R4 auto all empty no hit");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sbq.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule